// File: doc/BRIEF.md
# Serial HDLC Frame Receiver with Sticky Event Status

This block receives one bit-serial HDLC data link channel. Each bit comes with a valid strobe, and bits arrive least significant bit first. The receiver finds flag octets and drops the zero bit that is inserted after five ones. It packs the remaining bits into octets and stores them in a small message buffer. It runs a CRC-16/CCITT check over each frame. It also reports when seven ones in a row abort a frame and when a flag octet is seen.

Four events are kept as sticky bits in a status register. The host reads this register through a simple read port, and each bit clears on the read that returns it. An interrupt output combines the status bits with a 4-bit enable register that the host writes. A separate byte-read port lets the host fetch message bytes from the buffer. A length register holds the size of the last completed message.

Top module: `hdlc_rx`

## Requirements
- R1: The status register (read address 0) holds idle in bit 0, abort in bit 1, FCS error in bit 2 and end-of-reception in bit 3. Bits 7:4 read as 0. Reset clears all bits, the length register and the enable register.
- R2: Receiving the octet 0x7E (bit pattern 0, six ones, 0) sets the idle bit on the clock edge that samples its final 0.
- R3: The seventh consecutive 1 bit sets the abort bit and ends any frame in progress. Further 1 bits do not raise the event again until a 0 bit has been received.
- R4: Inside a frame, a 0 bit that follows exactly five 1 bits is removed before octet assembly. Octets are assembled with the first bit received as bit 0.
- R5: A closing flag that ends an octet-aligned frame of 4 or more bytes sets end-of-reception and idle on the same edge. After that flag the buffer holds every received byte in order, FCS bytes included, starting at buffer address 0.
- R6: The CRC (reflected polynomial 0x8408, preset 0xFFFF) runs over every frame byte including the FCS. When the result differs from 0xF0B8, the end of that frame also sets the FCS error bit.
- R7: A frame that closes with fewer than 4 bytes is discarded. It sets neither end-of-reception nor FCS error, and the length register is left unchanged.
- R8: The buffer holds 32 bytes. When the 32nd byte of a frame is stored, end-of-reception is set and the length register becomes 32. Later bytes of that frame are not stored.
- R9: A read of address 0 clears the status bits on the following edge. An event that occurs on the same edge as the clearing read leaves its bit set.
- R10: The interrupt output is high exactly when some status bit and its matching enable bit are both 1. The enable register is written through the configuration write port.
- R11: Read address 1 returns the byte count of the last completed message, which is also set by a buffer fill. Read address 2 returns the enable register in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxBit | input | 1 | Serial receive data |
| rxValid | input | 1 | rxBit holds a new bit this cycle |
| regRdEn | input | 1 | Register read strobe (a read of address 0 clears the status) |
| regAddr | input | 2 | Register read address: 0 status, 1 length, 2 enable |
| regRdData | output | 8 | Register read data (combinational) |
| cfgWrEn | input | 1 | Enable register write strobe |
| cfgWrData | input | 4 | Enable register write data |
| bufRdAddr | input | 5 | Message buffer byte address |
| bufRdData | output | 8 | Message buffer byte (combinational) |
| irqOut | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a status read that lands on the same edge as a new event. The read must clear the older bits and keep the new one. The bench gets there by driving the read strobe together with the seventh 1 of an abort sequence, while an earlier idle bit is still pending, and then expects only the abort bit. The buffer-full case is reached with a 34-byte frame, and the status is sampled right after the 32nd byte, before the closing flag arrives. All frames are built bit by bit in the bench, with its own zero insertion and its own CRC, so the removal of stuffed bits is exercised by data bytes 0xFF and 0x7E.

// File: rtl/hdlc_rx_pkg.sv
`timescale 1ns/1ps
package hdlc_rx_pkg;

  // Strobes from the bit-level control into the datapath
  typedef struct packed {
    logic       byteValid;
    logic [7:0] byteData;
    logic       flagSeen;
    logic       abortSeen;
    logic       frameEnd;
    logic       endAligned;
  } rxStrobe_t;

  localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
  localparam logic [15:0] CRC_POLYREV = 16'h8408;
  localparam logic [15:0] CRC_GOOD    = 16'hF0B8;

  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_LEN    = 2'd1;
  localparam logic [1:0] ADDR_ENABLE = 2'd2;

  // Fold one octet, LSB first, into a reflected CRC-16 register
  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ CRC_POLYREV;
    end
    return r;
  endfunction

endpackage

// File: rtl/hdlc_rx_ctrl.sv
`timescale 1ns/1ps
module hdlc_rx_ctrl
  import hdlc_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxBit,
  input  logic      rxValid,
  output rxStrobe_t strb
);

  logic [2:0] onesCnt;
  logic [2:0] bitCnt;
  logic [7:0] shReg;
  logic       inFrame;
  logic       isStuff, isFlag, isAbort, doPush;

  always_comb begin
    isStuff = rxValid && !rxBit && (onesCnt == 3'd5);
    isFlag  = rxValid && !rxBit && (onesCnt == 3'd6);
    isAbort = rxValid &&  rxBit && (onesCnt == 3'd6);
    doPush  = rxValid && inFrame && !isStuff && !isFlag && !isAbort;

    strb.byteValid  = doPush && (bitCnt == 3'd7);
    strb.byteData   = {rxBit, shReg[7:1]};
    strb.flagSeen   = isFlag;
    strb.abortSeen  = isAbort;
    strb.frameEnd   = isFlag && inFrame;
    strb.endAligned = (bitCnt == 3'd7);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      onesCnt <= '0;
      bitCnt  <= '0;
      shReg   <= '0;
      inFrame <= 1'b0;
    end else if (rxValid) begin
      if (rxBit) onesCnt <= (onesCnt == 3'd7) ? 3'd7 : onesCnt + 3'd1;
      else       onesCnt <= '0;

      if (isFlag) begin
        inFrame <= 1'b1;
        bitCnt  <= '0;
      end else if (isAbort) begin
        inFrame <= 1'b0;
        bitCnt  <= '0;
      end else if (doPush) begin
        shReg  <= {rxBit, shReg[7:1]};
        bitCnt <= bitCnt + 3'd1;
      end
    end
  end

  AST_STUFF_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (isStuff && inFrame) |=> $stable(bitCnt)) else $error("stuffed bit assembled"); // R4
  AST_ABORT_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    strb.abortSeen |=> !inFrame) else $error("frame survives abort"); // R3
  AST_BYTE_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    strb.byteValid |-> inFrame) else $error("byte outside frame"); // R5

endmodule

// File: rtl/hdlc_rx_dp.sv
`timescale 1ns/1ps
module hdlc_rx_dp
  import hdlc_rx_pkg::*;
#(
  parameter int BUF_DEPTH = 32,
  parameter int MIN_BYTES = 4,
  localparam int AW = $clog2(BUF_DEPTH),
  localparam int CW = $clog2(BUF_DEPTH + 1)
)(
  input  logic          clk,
  input  logic          rstN,
  input  rxStrobe_t     strb,
  input  logic          regRdEn,
  input  logic [1:0]    regAddr,
  input  logic          cfgWrEn,
  input  logic [3:0]    cfgWrData,
  input  logic [AW-1:0] bufRdAddr,
  output logic [7:0]    regRdData,
  output logic [7:0]    bufRdData,
  output logic [3:0]    statusQ,
  output logic [3:0]    enableQ
);

  logic [7:0]    mem [BUF_DEPTH];
  logic [CW-1:0] cnt, lenQ;
  logic [15:0]   crcQ;
  logic          frameOk, bufFull, statusClr;
  logic [3:0]    evt;

  always_comb begin
    frameOk   = strb.frameEnd && strb.endAligned && (cnt >= CW'(MIN_BYTES));
    bufFull   = strb.byteValid && (cnt == CW'(BUF_DEPTH - 1));
    evt       = {frameOk || bufFull, frameOk && (crcQ != CRC_GOOD),
                 strb.abortSeen, strb.flagSeen};
    statusClr = regRdEn && (regAddr == ADDR_STATUS);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      lenQ    <= '0;
      crcQ    <= CRC_PRESET;
      statusQ <= '0;
      enableQ <= '0;
    end else begin
      if (strb.flagSeen) begin
        cnt  <= '0;
        crcQ <= CRC_PRESET;
      end else if (strb.byteValid) begin
        crcQ <= crcStep(crcQ, strb.byteData);
        if (cnt < CW'(BUF_DEPTH)) cnt <= cnt + CW'(1);
      end
      if (frameOk)      lenQ <= cnt;
      else if (bufFull) lenQ <= CW'(BUF_DEPTH);
      statusQ <= (statusClr ? 4'b0 : statusQ) | evt;
      if (cfgWrEn) enableQ <= cfgWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.byteValid && !strb.flagSeen && (cnt < CW'(BUF_DEPTH)))
      mem[cnt[AW-1:0]] <= strb.byteData;
  end

  always_comb begin
    bufRdData = mem[bufRdAddr];
    case (regAddr)
      ADDR_STATUS: regRdData = {4'b0, statusQ};
      ADDR_LEN:    regRdData = 8'(lenQ);
      ADDR_ENABLE: regRdData = {4'b0, enableQ};
      default:     regRdData = '0;
    endcase
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CW'(BUF_DEPTH)) else $error("buffer count overrun"); // R8
  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !$past(statusClr) |-> ((statusQ & $past(statusQ)) == $past(statusQ)))
    else $error("status bit lost without read"); // R9
  AST_EOT_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusQ[3]) |-> (lenQ >= CW'(MIN_BYTES))) else $error("short frame reported"); // R7

endmodule

// File: rtl/hdlc_rx.sv
`timescale 1ns/1ps
module hdlc_rx
  import hdlc_rx_pkg::*;
#(
  parameter int BUF_DEPTH = 32,
  localparam int AW = $clog2(BUF_DEPTH)
)(
  input  logic          clk,
  input  logic          rstN,
  input  logic          rxBit,
  input  logic          rxValid,
  input  logic          regRdEn,
  input  logic [1:0]    regAddr,
  output logic [7:0]    regRdData,
  input  logic          cfgWrEn,
  input  logic [3:0]    cfgWrData,
  input  logic [AW-1:0] bufRdAddr,
  output logic [7:0]    bufRdData,
  output logic          irqOut
);

  rxStrobe_t  strb;
  logic [3:0] statusQ, enableQ;

  hdlc_rx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .rxValid(rxValid), .strb(strb)
  );

  hdlc_rx_dp #(.BUF_DEPTH(BUF_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .regRdEn(regRdEn), .regAddr(regAddr),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .bufRdAddr(bufRdAddr), .regRdData(regRdData), .bufRdData(bufRdData),
    .statusQ(statusQ), .enableQ(enableQ)
  );

  assign irqOut = |(statusQ & enableQ);

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ == 4'b0) |-> !irqOut) else $error("interrupt while masked"); // R10

endmodule

// File: tb/hdlc_rx_bench.sv
`timescale 1ns/1ps
module hdlc_rx_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxBit = 1'b1, rxValid = 1'b0;
  logic       regRdEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regRdData;
  logic       cfgWrEn = 1'b0;
  logic [3:0] cfgWrData = 4'd0;
  logic [4:0] bufRdAddr = 5'd0;
  logic [7:0] bufRdData;
  logic       irqOut;

  int checks = 0;
  int fails = 0;
  int onesRun = 0;
  logic [7:0] v;

  hdlc_rx u_hdlc_rx (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .rxValid(rxValid),
    .regRdEn(regRdEn), .regAddr(regAddr), .regRdData(regRdData),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .bufRdAddr(bufRdAddr), .bufRdData(bufRdData), .irqOut(irqOut)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic rawBit(input logic b, input logic rd = 1'b0);
    @(negedge clk);
    rxBit = b; rxValid = 1'b1; regAddr = 2'd0; regRdEn = rd;
  endtask

  task automatic quiet();
    @(negedge clk);
    rxValid = 1'b0; regRdEn = 1'b0; cfgWrEn = 1'b0;
  endtask

  task automatic sendFlag();
    rawBit(0);
    for (int i = 0; i < 6; i++) rawBit(1);
    rawBit(0);
    onesRun = 0;
    quiet();
  endtask

  task automatic sendByte(input logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      rawBit(d[i]);
      onesRun = d[i] ? onesRun + 1 : 0;
      if (onesRun == 5) begin
        rawBit(0);
        onesRun = 0;
      end
    end
    quiet();
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rxValid = 1'b0; regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic readBuf(input int idx, output logic [7:0] d);
    @(negedge clk);
    bufRdAddr = 5'(idx);
    #1 d = bufRdData;
  endtask

  task automatic writeEn(input logic [3:0] e);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = e;
    quiet();
  endtask

  function automatic logic [15:0] fcsOf(input logic [7:0] q[$]);
    logic [15:0] c;
    logic fb;
    c = 16'hFFFF;
    foreach (q[k]) begin
      for (int i = 0; i < 8; i++) begin
        fb = c[0] ^ q[k][i];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    end
    return ~c;
  endfunction

  // Opening flag, clear pending status, body, FCS (optionally corrupted), closing flag
  task automatic sendFrame(input logic [7:0] q[$], input logic [15:0] fcsFlip);
    logic [15:0] f;
    logic [7:0] d;
    f = fcsOf(q) ^ fcsFlip;
    sendFlag();
    readReg(2'd0, d);
    foreach (q[k]) sendByte(q[k]);
    sendByte(f[7:0]);
    sendByte(f[15:8]);
    sendFlag();
  endtask

  task automatic tReset();
    readReg(2'd0, v); chk("R1", "status after reset", 16'(v), 16'h00);
    readReg(2'd1, v); chk("R11", "length after reset", 16'(v), 16'h00);
    readReg(2'd2, v); chk("R1", "enable after reset", 16'(v), 16'h00);
    chk("R10", "irq after reset", 16'(irqOut), 16'h0);
  endtask

  task automatic tIdle();
    sendFlag();
    readReg(2'd0, v); chk("R2", "idle on flag", 16'(v), 16'h01);
    readReg(2'd0, v); chk("R9", "status cleared by read", 16'(v), 16'h00);
  endtask

  task automatic tGood();
    logic [7:0] q[$];
    logic [15:0] f;
    q = '{8'hFF, 8'h03, 8'hA5, 8'h7E, 8'h3C};
    f = fcsOf(q);
    sendFrame(q, 16'h0);
    readReg(2'd0, v); chk("R5", "eot and idle together", 16'(v), 16'h09);
    readReg(2'd1, v); chk("R11", "length good frame", 16'(v), 16'd7);
    readBuf(0, v); chk("R4", "buf[0] 0xFF destuffed", 16'(v), 16'hFF);
    readBuf(3, v); chk("R4", "buf[3] 0x7E destuffed", 16'(v), 16'h7E);
    readBuf(4, v); chk("R5", "buf[4]", 16'(v), 16'h3C);
    readBuf(5, v); chk("R5", "buf[5] fcs low", 16'(v), 16'(f[7:0]));
  endtask

  task automatic tBadFcs();
    logic [7:0] q[$];
    q = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    sendFrame(q, 16'h0100);
    readReg(2'd0, v); chk("R6", "fcs error frame", 16'(v), 16'h0D);
    readReg(2'd1, v); chk("R6", "length bad frame", 16'(v), 16'd8);
  endtask

  task automatic tShort();
    sendFlag();
    readReg(2'd0, v);
    sendByte(8'h12);
    sendByte(8'h34);
    sendFlag();
    readReg(2'd0, v); chk("R7", "short frame status", 16'(v), 16'h01);
    readReg(2'd1, v); chk("R7", "length untouched", 16'(v), 16'd8);
  endtask

  task automatic tAbort();
    sendFlag();
    readReg(2'd0, v);
    sendByte(8'h5A);
    sendByte(8'h81);
    for (int i = 0; i < 7; i++) rawBit(1);
    quiet();
    readReg(2'd0, v); chk("R3", "abort on seven ones", 16'(v), 16'h02);
    for (int i = 0; i < 5; i++) rawBit(1);
    quiet();
    readReg(2'd0, v); chk("R3", "no repeat abort", 16'(v), 16'h00);
    onesRun = 0;
  endtask

  task automatic tSameCycle();
    sendFlag();
    sendByte(8'h00);
    for (int i = 0; i < 6; i++) rawBit(1);
    rawBit(1, 1'b1);
    quiet();
    readReg(2'd0, v); chk("R9", "event survives same-edge read", 16'(v), 16'h02);
    onesRun = 0;
  endtask

  task automatic tFull();
    logic [7:0] q[$];
    logic [15:0] f;
    for (int i = 0; i < 34; i++) q.push_back(8'(i * 7 + 1));
    f = fcsOf(q);
    sendFlag();
    readReg(2'd0, v);
    for (int i = 0; i < 32; i++) sendByte(q[i]);
    readReg(2'd0, v); chk("R8", "eot on buffer full", 16'(v), 16'h08);
    readReg(2'd1, v); chk("R8", "length at full", 16'(v), 16'd32);
    sendByte(q[32]);
    sendByte(q[33]);
    sendByte(f[7:0]);
    sendByte(f[15:8]);
    sendFlag();
    readReg(2'd0, v); chk("R8", "long frame close", 16'(v), 16'h09);
    readBuf(0, v); chk("R8", "buf[0] kept", 16'(v), 16'h01);
    readBuf(31, v); chk("R8", "buf[31] not overwritten", 16'(v), 16'hDA);
  endtask

  task automatic tIrq();
    logic [7:0] q[$];
    q = '{8'hC0, 8'hDE, 8'h0F, 8'hAA};
    writeEn(4'b1000);
    readReg(2'd2, v); chk("R11", "enable readback", 16'(v), 16'h08);
    sendFrame(q, 16'h0);
    #1 chk("R10", "irq on enabled eot", 16'(irqOut), 16'h1);
    writeEn(4'b0100);
    #1 chk("R10", "irq masked", 16'(irqOut), 16'h0);
    writeEn(4'b0001);
    #1 chk("R10", "irq on enabled idle", 16'(irqOut), 16'h1);
    readReg(2'd0, v);
    #1 chk("R10", "irq after clear", 16'(irqOut), 16'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tIdle();
    tGood();
    tBadFcs();
    tShort();
    tAbort();
    tSameCycle();
    tFull();
    tIrq();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule